// File: doc/BRIEF.md
# Hardware Thread Run-State Controller

This block holds the run state of a small array of hardware thread contexts and updates it on commands from the execute stage. Each context carries an active flag, a halted flag, an allocatable flag, a dirty flag, a restart address, a three-stage program-counter set (current, next and next-next), and a binding made of a virtual-processor number and a context number. One exception-code register is shared by the contexts.

Four commands are accepted, one per cycle: halt, restore, yield and setup. The setup command writes a context's attributes and restart address. Halt and restore stop and resume a context. Yield reads a signed source operand. A zero operand may deactivate the caller. A positive operand with an empty mask raises a fault. A negative operand may raise a fault when the scheduler-intercept bit is set. The operand value minus two is a quiet no-op.

Each command is followed one cycle later by a done strobe, with a fault pulse when one applies. Each yield also returns the AND of the operand and the mask. A combinational read port exposes one context's full state, and a vector shows every context's active flag.

Top module: `thread_runctl`

## Requirements
- R1: After reset, context 0 is active and every other context is inactive. Every context is unhalted, not allocatable and clean, with virtual processor 0, context number equal to its index, and all addresses 0. The exception code, the yield result, done and fault are 0.
- R2: A halt command (cmd_op=0) on an active context clears its active flag and stores cmd_pc into its restart address.
- R3: A halt command on an inactive context changes no state.
- R4: A restore command (cmd_op=1) on an inactive context sets PC to the restart address, next-PC to restart+4 and next-next-PC to restart+8, and sets the active flag.
- R5: A restore command on an active context changes no state.
- R6: A yield command (cmd_op=2) with operand 0 checks contexts 0 through cfg_last_ctx. If any of them has the caller's virtual-processor number and context number and is allocatable, unhalted and active, the caller's active flag is cleared. Otherwise nothing changes.
- R7: A yield with a positive operand and a zero mask writes exception code 2 and pulses fault. A nonzero mask gives no fault.
- R8: A yield with a negative operand other than -2 writes exception code 4 and pulses fault when sched_intercept and the caller's dirty flag are both 1. Otherwise it has no effect.
- R9: A yield with operand -2 changes no state and raises no fault.
- R10: Every command is followed, one cycle later, by exactly one cycle of done. Every yield updates yield_result to yield_src AND yield_mask. Fault is only ever raised by a yield.
- R11: A setup command (cmd_op=3) writes the halted, allocatable and dirty flags, the virtual-processor number, the context number, and the restart address (from cmd_pc) of the addressed context. It leaves that context's active flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 halt, 1 restore, 2 yield, 3 setup |
| cmd_ctx | input | CW | Target context (the caller for yield) |
| cmd_pc | input | AW | Next-PC for halt, restart address for setup |
| yield_src | input | DW | Signed yield operand |
| yield_mask | input | DW | Yield mask |
| cfg_last_ctx | input | CW | Number of contexts scanned, minus one |
| sched_intercept | input | 1 | Scheduler-intercept control bit |
| set_halted | input | 1 | Setup value for halted |
| set_alloc | input | 1 | Setup value for allocatable |
| set_dirty | input | 1 | Setup value for dirty |
| set_vp | input | VPW | Setup value for virtual-processor number |
| set_tcn | input | CW | Setup value for context number |
| rd_ctx | input | CW | Context selected on the read port |
| done | output | 1 | Command completed (one cycle after it) |
| fault | output | 1 | Fault pulse with done |
| yield_result | output | DW | Operand AND mask of the last yield |
| excode | output | EXW | Shared exception code |
| active_vec | output | NCTX | Active flag of each context |
| rd_halted | output | 1 | Halted flag of rd_ctx |
| rd_alloc | output | 1 | Allocatable flag of rd_ctx |
| rd_dirty | output | 1 | Dirty flag of rd_ctx |
| rd_vp | output | VPW | Virtual-processor number of rd_ctx |
| rd_tcn | output | CW | Context number of rd_ctx |
| rd_restart | output | AW | Restart address of rd_ctx |
| rd_pc | output | AW | PC of rd_ctx |
| rd_npc | output | AW | Next-PC of rd_ctx |
| rd_nnpc | output | AW | Next-next-PC of rd_ctx |

## Verification
The bound checker watches the command handshake on every cycle. It checks that each command produces one done cycle and that no fault appears after a non-yield command. It checks that any fault carries code 2 or 4. It also checks the active-flag effect of halt and restore, and that a yield with operand -2 is quiet.

The finer cases can only be shown by the bench's scenarios running against its reference model. These are the zero-operand scan bounded by cfg_last_ctx and by the binding match, the dependence of the negative-operand fault on both intercept and dirty, and the restart-address arithmetic of restore.

// File: rtl/thread_runctl.sv
module thread_runctl #(
  parameter int NCTX = 4,
  parameter int VPW  = 2,
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int EXW  = 5,
  localparam int CW  = (NCTX > 1) ? $clog2(NCTX) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [CW-1:0] cmd_ctx,
  input  logic [AW-1:0] cmd_pc,
  input  logic [DW-1:0] yield_src,
  input  logic [DW-1:0] yield_mask,
  input  logic [CW-1:0] cfg_last_ctx,
  input  logic          sched_intercept,
  input  logic          set_halted,
  input  logic          set_alloc,
  input  logic          set_dirty,
  input  logic [VPW-1:0] set_vp,
  input  logic [CW-1:0] set_tcn,
  input  logic [CW-1:0] rd_ctx,
  output logic          done,
  output logic          fault,
  output logic [DW-1:0] yield_result,
  output logic [EXW-1:0] excode,
  output logic [NCTX-1:0] active_vec,
  output logic          rd_halted,
  output logic          rd_alloc,
  output logic          rd_dirty,
  output logic [VPW-1:0] rd_vp,
  output logic [CW-1:0] rd_tcn,
  output logic [AW-1:0] rd_restart,
  output logic [AW-1:0] rd_pc,
  output logic [AW-1:0] rd_npc,
  output logic [AW-1:0] rd_nnpc
);
  localparam logic [1:0] OP_HALT = 2'd0, OP_RESTORE = 2'd1, OP_YIELD = 2'd2, OP_SETUP = 2'd3;
  localparam logic [DW-1:0] SRC_QUIET = ~DW'(1);

  logic [NCTX-1:0] active, halted, alloc, dirty;
  logic [VPW-1:0]  vp      [NCTX];
  logic [CW-1:0]   tcn     [NCTX];
  logic [AW-1:0]   restart [NCTX];
  logic [AW-1:0]   pc      [NCTX];
  logic [AW-1:0]   npc     [NCTX];
  logic [AW-1:0]   nnpc    [NCTX];

  logic match;
  always_comb begin
    match = 1'b0;
    for (int i = 0; i < NCTX; i++)
      if (CW'(i) <= cfg_last_ctx && vp[i] == vp[cmd_ctx] && tcn[i] == tcn[cmd_ctx] &&
          alloc[i] && !halted[i] && active[i])
        match = 1'b1;
  end

  wire src_zero = (yield_src == '0);
  wire src_neg  = yield_src[DW-1];
  wire src_pos  = !src_neg && !src_zero;
  wire is_yield = cmd_valid && cmd_op == OP_YIELD;
  wire trap_mask  = is_yield && src_pos && (yield_mask == '0);
  wire trap_sched = is_yield && src_neg && (yield_src != SRC_QUIET) && sched_intercept && dirty[cmd_ctx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active       <= NCTX'(1);
      halted       <= '0;
      alloc        <= '0;
      dirty        <= '0;
      done         <= 1'b0;
      fault        <= 1'b0;
      yield_result <= '0;
      excode       <= '0;
      for (int i = 0; i < NCTX; i++) begin
        vp[i]      <= '0;
        tcn[i]     <= CW'(i);
        restart[i] <= '0;
        pc[i]      <= '0;
        npc[i]     <= '0;
        nnpc[i]    <= '0;
      end
    end else begin
      done  <= cmd_valid;
      fault <= trap_mask || trap_sched;
      if (trap_mask)  excode <= EXW'(2);
      if (trap_sched) excode <= EXW'(4);
      if (cmd_valid) begin
        case (cmd_op)
          OP_HALT: if (active[cmd_ctx]) begin
            active[cmd_ctx]  <= 1'b0;
            restart[cmd_ctx] <= cmd_pc;
          end
          OP_RESTORE: if (!active[cmd_ctx]) begin
            pc[cmd_ctx]     <= restart[cmd_ctx];
            npc[cmd_ctx]    <= restart[cmd_ctx] + AW'(4);
            nnpc[cmd_ctx]   <= restart[cmd_ctx] + AW'(8);
            active[cmd_ctx] <= 1'b1;
          end
          OP_YIELD: begin
            yield_result <= yield_src & yield_mask;
            if (src_zero && match) active[cmd_ctx] <= 1'b0;
          end
          default: begin
            halted[cmd_ctx]  <= set_halted;
            alloc[cmd_ctx]   <= set_alloc;
            dirty[cmd_ctx]   <= set_dirty;
            vp[cmd_ctx]      <= set_vp;
            tcn[cmd_ctx]     <= set_tcn;
            restart[cmd_ctx] <= cmd_pc;
          end
        endcase
      end
    end
  end

  assign active_vec = active;
  assign rd_halted  = halted[rd_ctx];
  assign rd_alloc   = alloc[rd_ctx];
  assign rd_dirty   = dirty[rd_ctx];
  assign rd_vp      = vp[rd_ctx];
  assign rd_tcn     = tcn[rd_ctx];
  assign rd_restart = restart[rd_ctx];
  assign rd_pc      = pc[rd_ctx];
  assign rd_npc     = npc[rd_ctx];
  assign rd_nnpc    = nnpc[rd_ctx];
endmodule

module thread_runctl_chk #(
  parameter int NCTX = 4,
  parameter int DW   = 32,
  parameter int EXW  = 5,
  parameter int CW   = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic [1:0]      cmd_op,
  input logic [CW-1:0]   cmd_ctx,
  input logic [DW-1:0]   yield_src,
  input logic            done,
  input logic            fault,
  input logic [EXW-1:0]  excode,
  input logic [NCTX-1:0] active_vec
);
  a_r10_done_follows: assert property (@(posedge clk) disable iff (!rst_n) cmd_valid |=> done);
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n) !cmd_valid |=> !done);
  a_r10_fault_yield_only: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op != 2'd2) |=> !fault);
  a_r7_fault_code: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (excode == EXW'(2) || excode == EXW'(4)));
  a_r2_halt_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd0 && active_vec[cmd_ctx]) |=> !active_vec[$past(cmd_ctx)]);
  a_r4_restore_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd1 && !active_vec[cmd_ctx]) |=> active_vec[$past(cmd_ctx)]);
  a_r5_restore_active_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd1 && active_vec[cmd_ctx]) |=> $stable(active_vec));
  a_r9_quiet_yield: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd2 && yield_src == ~DW'(1)) |=> (!fault && $stable(active_vec) && $stable(excode)));
endmodule

bind thread_runctl thread_runctl_chk #(.NCTX(NCTX), .DW(DW), .EXW(EXW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_ctx(cmd_ctx),
  .yield_src(yield_src), .done(done), .fault(fault), .excode(excode), .active_vec(active_vec)
);

// File: tb/thread_runctl_bench.sv
module thread_runctl_bench;
  localparam int NCTX = 4, VPW = 2, AW = 32, DW = 32, EXW = 5, CW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic cmd_valid = 0; logic [1:0] cmd_op = 0; logic [CW-1:0] cmd_ctx = 0;
  logic [AW-1:0] cmd_pc = 0; logic [DW-1:0] yield_src = 0, yield_mask = 0;
  logic [CW-1:0] cfg_last_ctx = 2'd3; logic sched_intercept = 0;
  logic set_halted = 0, set_alloc = 0, set_dirty = 0;
  logic [VPW-1:0] set_vp = 0; logic [CW-1:0] set_tcn = 0; logic [CW-1:0] rd_ctx = 0;
  logic done, fault; logic [DW-1:0] yield_result; logic [EXW-1:0] excode;
  logic [NCTX-1:0] active_vec; logic rd_halted, rd_alloc, rd_dirty;
  logic [VPW-1:0] rd_vp; logic [CW-1:0] rd_tcn;
  logic [AW-1:0] rd_restart, rd_pc, rd_npc, rd_nnpc;

  thread_runctl #(.NCTX(NCTX), .VPW(VPW), .AW(AW), .DW(DW), .EXW(EXW)) u_thread_runctl (.*);

  // reference model
  bit m_act[NCTX], m_hlt[NCTX], m_all[NCTX], m_drt[NCTX];
  int m_vp[NCTX], m_tcn[NCTX];
  logic [AW-1:0] m_rst[NCTX], m_pc[NCTX], m_npc[NCTX], m_nnpc[NCTX];
  bit m_done, m_fault; logic [DW-1:0] m_yres; int m_exc;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCTX; i++) begin
        m_act[i] = (i == 0); m_hlt[i] = 0; m_all[i] = 0; m_drt[i] = 0;
        m_vp[i] = 0; m_tcn[i] = i; m_rst[i] = 0; m_pc[i] = 0; m_npc[i] = 0; m_nnpc[i] = 0;
      end
      m_done = 0; m_fault = 0; m_yres = 0; m_exc = 0;
    end else begin
      int c; c = cmd_ctx;
      m_done = cmd_valid; m_fault = 0;
      if (cmd_valid) begin
        if (cmd_op == 0) begin
          if (m_act[c]) begin m_act[c] = 0; m_rst[c] = cmd_pc; end
        end else if (cmd_op == 1) begin
          if (!m_act[c]) begin
            m_pc[c] = m_rst[c]; m_npc[c] = m_rst[c] + 4; m_nnpc[c] = m_rst[c] + 8; m_act[c] = 1;
          end
        end else if (cmd_op == 2) begin
          int s; s = $signed(yield_src);
          m_yres = yield_src & yield_mask;
          if (s == 0) begin
            bit hit; hit = 0;
            for (int i = 0; i <= int'(cfg_last_ctx); i++)
              if (m_vp[i] == m_vp[c] && m_tcn[i] == m_tcn[c] && m_all[i] && !m_hlt[i] && m_act[i]) hit = 1;
            if (hit) m_act[c] = 0;
          end else if (s > 0) begin
            if (yield_mask == 0) begin m_exc = 2; m_fault = 1; end
          end else if (s != -2) begin
            if (sched_intercept && m_drt[c]) begin m_exc = 4; m_fault = 1; end
          end
        end else begin
          m_hlt[c] = set_halted; m_all[c] = set_alloc; m_drt[c] = set_dirty;
          m_vp[c] = set_vp; m_tcn[c] = set_tcn; m_rst[c] = cmd_pc;
        end
      end
    end
  end

  int compared = 0, mismatched = 0, cyc = 0;
  string cur_req = "R1";
  bit finished = 0;

  task automatic chk(string what, longint act, longint exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", cur_req, what, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    int r;
    rd_ctx = CW'(cyc % NCTX);
    #1;
    r = rd_ctx;
    if (rst_n) begin
      logic [NCTX-1:0] av;
      for (int i = 0; i < NCTX; i++) av[i] = m_act[i];
      chk("done", done, m_done);
      chk("fault", fault, m_fault);
      chk("yield_result", yield_result, m_yres);
      chk("excode", excode, m_exc);
      chk("active_vec", active_vec, av);
      chk("halted", rd_halted, m_hlt[r]);
      chk("alloc", rd_alloc, m_all[r]);
      chk("dirty", rd_dirty, m_drt[r]);
      chk("vp", rd_vp, m_vp[r]);
      chk("tcn", rd_tcn, m_tcn[r]);
      chk("restart", rd_restart, m_rst[r]);
      chk("pc", rd_pc, m_pc[r]);
      chk("npc", rd_npc, m_npc[r]);
      chk("nnpc", rd_nnpc, m_nnpc[r]);
    end
    cyc++;
  end

  task automatic issue(input logic [1:0] op, input int c, input logic [AW-1:0] pcv,
                       input logic [DW-1:0] src, input logic [DW-1:0] msk);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_ctx = CW'(c); cmd_pc = pcv; yield_src = src; yield_mask = msk;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic setup(input int c, input bit h, input bit a, input bit d, input int v, input int t,
                       input logic [AW-1:0] rs);
    set_halted = h; set_alloc = a; set_dirty = d; set_vp = VPW'(v); set_tcn = CW'(t);
    issue(2'd3, c, rs, 0, 0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #200000;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    mismatched++;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R1"; idle(6);
    cur_req = "R11"; setup(1, 0, 1, 1, 0, 1, 32'h100); idle(4);
    cur_req = "R2"; issue(2'd0, 0, 32'h2000, 0, 0); idle(4);
    cur_req = "R3"; issue(2'd0, 0, 32'h3000, 0, 0); idle(4);
    cur_req = "R4"; issue(2'd1, 0, 0, 0, 0); idle(4);
    cur_req = "R11"; setup(0, 0, 1, 0, 0, 0, 32'h4000); idle(4);
    cur_req = "R5"; issue(2'd1, 0, 0, 0, 0); idle(4);
    cur_req = "R6"; issue(2'd2, 0, 0, 0, 32'hFF); idle(4);
    issue(2'd1, 0, 0, 0, 0);
    issue(2'd2, 3, 0, 0, 32'h1); idle(4);
    setup(2, 0, 1, 0, 1, 2, 32'h500); issue(2'd1, 2, 0, 0, 0);
    cfg_last_ctx = 2'd1; issue(2'd2, 2, 0, 0, 0); idle(4);
    cfg_last_ctx = 2'd3; issue(2'd2, 2, 0, 0, 0); idle(4);
    cur_req = "R7"; issue(2'd2, 0, 0, 32'h5, 32'h0); idle(4);
    issue(2'd2, 0, 0, 32'h7, 32'h6); idle(4);
    cur_req = "R8"; sched_intercept = 1; issue(2'd2, 0, 0, 32'h5, 32'h0);
    issue(2'd2, 1, 0, -32'sd5, 32'hF0F0); idle(4);
    sched_intercept = 0; issue(2'd2, 1, 0, -32'sd9, 32'hFFFF); idle(2);
    sched_intercept = 1; issue(2'd2, 0, 0, -32'sd1, 32'hFFFF); idle(4);
    cur_req = "R9"; issue(2'd2, 1, 0, -32'sd2, 32'hFFFF_FFFF); idle(4);
    cur_req = "R10";
    @(negedge clk);
    cmd_valid = 1; cmd_op = 2; cmd_ctx = 1; yield_src = 32'h1234; yield_mask = 32'h0FF0;
    @(negedge clk); cmd_op = 0; cmd_ctx = 1; cmd_pc = 32'h777;
    @(negedge clk); cmd_op = 1;
    @(negedge clk); cmd_valid = 0; idle(4);
    cur_req = "R10";
    for (int k = 0; k < 400; k++) begin
      int pick;
      logic [DW-1:0] src;
      pick = $urandom_range(0, 4);
      src = (pick == 0) ? 0 : (pick == 1) ? ~DW'(1) : (pick == 2) ? DW'($urandom_range(1, 50)) :
            (pick == 3) ? -DW'($urandom_range(1, 5)) : DW'($urandom);
      cfg_last_ctx = CW'($urandom_range(0, NCTX - 1));
      sched_intercept = 1'($urandom);
      set_halted = 1'($urandom); set_alloc = 1'($urandom); set_dirty = 1'($urandom);
      set_vp = VPW'($urandom); set_tcn = CW'($urandom);
      @(negedge clk);
      cmd_valid = 1'($urandom); cmd_op = 2'($urandom); cmd_ctx = CW'($urandom);
      cmd_pc = AW'($urandom) & ~AW'(3); yield_src = src;
      yield_mask = ($urandom_range(0, 3) == 0) ? '0 : DW'($urandom);
    end
    @(negedge clk); cmd_valid = 0; idle(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule